// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and decides when the core leaves its program to enter an interrupt handler. There are three possible causes. A non-maskable request arrives on an active-low input and is caught on its falling edge. A maskable request arrives on an active-low input and is level-sensitive. The third cause is the software break opcode, which the core reports at an instruction boundary.

When the core signals an instruction boundary and a cause is pending, the block raises a one-cycle grant and takes over the bus. It pushes the return address, high byte first, then the low byte. It then pushes a formatted status byte and sets the mask flag. Finally it reads the two vector bytes and returns the assembled handler address with a done pulse. A step input lets the core stall any bus cycle of the sequence.

The core returns from interrupt with its own logic. On that return it hands the popped mask bit back to this block through a restore input.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle with `mask_o`=1, `we_o`=0, `vec_pull_no`=1, `busy_o`=0 and `done_o`=0.
- R2: A falling edge on `nmi_ni` arms a pending entry. The entry is granted at the next cycle with `boundary_i`=1, and its vector bytes are read from 0xFFFA then 0xFFFB.
- R3: While `nmi_ni` stays low after its edge has been taken, no further entry is granted. A new entry needs a rise and then another fall.
- R4: A falling edge on `nmi_ni` during a running entry sequence is kept. It is granted at the first boundary after that sequence ends.
- R5: A low `irq_ni` is ignored while `mask_o`=1. When `mask_o`=0 it is granted at a boundary, and its vector bytes are read from 0xFFFE then 0xFFFF.
- R6: The three pushes go to 0x0100+sp, 0x0100+sp-1 and 0x0100+sp-2, with the 8-bit stack offset wrapping. `sp` is `sp_i` at grant, and `sp_o` ends at sp-3.
- R7: The pushed status byte has bit7=N, bit6=V, bit5=1, bit4=B, bit3=D, bit2=I, bit1=Z and bit0=C. N, V, D, Z and C come from `flags_i` at grant. I is the mask value before the entry. B is 1 for a software break and 0 for a hardware request.
- R8: A software break (`brk_i`=1 at a boundary with no hardware request) pushes `pc_i`+2, skipping the padding byte. It uses the 0xFFFE/0xFFFF vector.
- R9: `mask_o` becomes 1 after the status push and stays 1 through both vector reads.
- R10: `we_o` is high only in the three push cycles. `vec_pull_no` is low only in the two vector read cycles.
- R11: When a non-maskable edge and an unmasked maskable request are both pending at a boundary, the non-maskable vector is used.
- R12: With `step_i`=0 during a sequence, the bus outputs and the sequence step hold.
- R13: When idle, a `restore_i` pulse loads `mask_o` from `restore_mask_i`.
- R14: One cycle after the high vector read, `done_o` pulses for one cycle and `target_o` equals {high byte, low byte} of the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance the sequence this cycle |
| boundary_i | input | 1 | Core is at an instruction boundary |
| brk_i | input | 1 | Opcode at this boundary is a software break |
| irq_ni | input | 1 | Maskable request, active low, level |
| nmi_ni | input | 1 | Non-maskable request, active low, edge |
| pc_i | input | 16 | Return address (break: address of the opcode) |
| sp_i | input | 8 | Stack offset at the boundary |
| flags_i | input | 8 | Core flags in status-byte positions |
| restore_i | input | 1 | Load mask from popped status |
| restore_mask_i | input | 1 | Popped mask bit |
| vec_data_i | input | 8 | Read data during vector reads |
| grant_o | output | 1 | Entry accepted this cycle |
| busy_o | output | 1 | Sequence running |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Push data |
| we_o | output | 1 | Push write strobe |
| vec_pull_no | output | 1 | Vector read strobe, active low |
| mask_o | output | 1 | Maskable-request disable flag |
| sp_o | output | 8 | Working stack offset |
| target_o | output | 16 | Assembled handler address |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The assertions assume that `step_i` only stalls cycles and never aborts a sequence. They also assume that the core raises `boundary_i` only when it is free to give up the bus. For these reasons they are written against the block's own bus strobes and never against the request inputs. The stimulus changes every input on the falling clock edge. It holds `nmi_ni` steady for at least one full cycle around each edge, so the edge detector sees every transition it is meant to see. It raises `restore_i` only while the block is idle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P, ST_VEC_L, ST_VEC_H
  } seq_state_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_IRQ, SRC_BRK} src_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_ni,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q;

  // a new fall wins over a same-cycle take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b1;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_ni;
      pend_o <= (pend_o & ~take_i) | (nmi_q & ~nmi_ni);
    end
  end
endmodule

// File: rtl/irq_status_fmt.sv
module irq_status_fmt #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] flags_i,
  input  logic          brk_i,
  input  logic          mask_i,
  output logic [DW-1:0] status_o
);
  localparam logic [DW-1:0] KEEP = DW'(8'hCB);
  localparam logic [DW-1:0] ONE5 = DW'(8'h20);

  always_comb begin
    status_o    = (flags_i & KEEP) | ONE5;
    status_o[4] = brk_i;
    status_o[2] = mask_i;
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   STACK_HI = 8'h01,
  parameter logic [AW-1:0]   VEC_NMI  = 16'hFFFA,
  parameter logic [AW-1:0]   VEC_IRQ  = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          boundary_i,
  input  logic          nmi_pend_i,
  input  logic          irq_req_i,
  input  logic          brk_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] flags_i,
  input  logic          restore_i,
  input  logic          restore_mask_i,
  input  logic [DW-1:0] vec_data_i,
  input  logic [DW-1:0] status_i,
  output logic          grant_o,
  output logic          take_nmi_o,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          vec_pull_no,
  output logic          mask_o,
  output logic [DW-1:0] sp_o,
  output logic [AW-1:0] target_o,
  output logic          done_o,
  output logic [DW-1:0] flags_o,
  output logic          is_brk_o
);
  localparam int SPW = AW - DW;

  seq_state_e    state_q;
  src_e          src_sel, src_q;
  logic [AW-1:0] ret_q;
  logic [DW-1:0] vec_lo_q;
  logic [AW-1:0] vec_base;

  always_comb begin
    if (nmi_pend_i)     src_sel = SRC_NMI;
    else if (irq_req_i) src_sel = SRC_IRQ;
    else if (brk_i)     src_sel = SRC_BRK;
    else                src_sel = SRC_NONE;
  end

  assign grant_o    = (state_q == ST_IDLE) && boundary_i && (src_sel != SRC_NONE);
  assign take_nmi_o = grant_o && (src_sel == SRC_NMI);
  assign busy_o     = (state_q != ST_IDLE);
  assign is_brk_o   = (src_q == SRC_BRK);
  assign vec_base   = (src_q == SRC_NMI) ? VEC_NMI : VEC_IRQ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      src_q    <= SRC_NONE;
      ret_q    <= '0;
      flags_o  <= '0;
      sp_o     <= '1;
      vec_lo_q <= '0;
      target_o <= '0;
      done_o   <= 1'b0;
      mask_o   <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (grant_o) begin
        state_q <= ST_PUSH_H;
        src_q   <= src_sel;
        ret_q   <= (src_sel == SRC_BRK) ? pc_i + AW'(2) : pc_i;
        flags_o <= flags_i;
        sp_o    <= sp_i;
      end else if (busy_o && step_i) begin
        unique case (state_q)
          ST_PUSH_H: begin sp_o <= sp_o - 1'b1; state_q <= ST_PUSH_L; end
          ST_PUSH_L: begin sp_o <= sp_o - 1'b1; state_q <= ST_PUSH_P; end
          ST_PUSH_P: begin
            sp_o    <= sp_o - 1'b1;
            mask_o  <= 1'b1;
            state_q <= ST_VEC_L;
          end
          ST_VEC_L: begin vec_lo_q <= vec_data_i; state_q <= ST_VEC_H; end
          ST_VEC_H: begin
            target_o <= {vec_data_i, vec_lo_q};
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end else if (!busy_o && restore_i) begin
        mask_o <= restore_mask_i;
      end
    end
  end

  always_comb begin
    addr_o      = '0;
    wdata_o     = '0;
    we_o        = 1'b0;
    vec_pull_no = 1'b1;
    unique case (state_q)
      ST_PUSH_H: begin
        addr_o = {STACK_HI, sp_o}; wdata_o = ret_q[AW-1:SPW]; we_o = 1'b1;
      end
      ST_PUSH_L: begin
        addr_o = {STACK_HI, sp_o}; wdata_o = ret_q[DW-1:0]; we_o = 1'b1;
      end
      ST_PUSH_P: begin
        addr_o = {STACK_HI, sp_o}; wdata_o = status_i; we_o = 1'b1;
      end
      ST_VEC_L: begin addr_o = vec_base;          vec_pull_no = 1'b0; end
      ST_VEC_H: begin addr_o = vec_base | AW'(1); vec_pull_no = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          boundary_i,
  input  logic          brk_i,
  input  logic          irq_ni,
  input  logic          nmi_ni,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] flags_i,
  input  logic          restore_i,
  input  logic          restore_mask_i,
  input  logic [DW-1:0] vec_data_i,
  output logic          grant_o,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          vec_pull_no,
  output logic          mask_o,
  output logic [DW-1:0] sp_o,
  output logic [AW-1:0] target_o,
  output logic          done_o
);
  logic          nmi_pend, take_nmi, is_brk;
  logic [DW-1:0] flags_q, status;

  irq_nmi_latch u_nmi (
    .clk_i (clk_i), .rst_ni(rst_ni), .nmi_ni(nmi_ni),
    .take_i(take_nmi), .pend_o(nmi_pend)
  );

  irq_status_fmt #(.DW(DW)) u_fmt (
    .flags_i(flags_q), .brk_i(is_brk), .mask_i(mask_o), .status_o(status)
  );

  irq_entry_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (step_i),
    .boundary_i    (boundary_i),
    .nmi_pend_i    (nmi_pend),
    .irq_req_i     (~irq_ni & ~mask_o),
    .brk_i         (brk_i),
    .pc_i          (pc_i),
    .sp_i          (sp_i),
    .flags_i       (flags_i),
    .restore_i     (restore_i),
    .restore_mask_i(restore_mask_i),
    .vec_data_i    (vec_data_i),
    .status_i      (status),
    .grant_o       (grant_o),
    .take_nmi_o    (take_nmi),
    .busy_o        (busy_o),
    .addr_o        (addr_o),
    .wdata_o       (wdata_o),
    .we_o          (we_o),
    .vec_pull_no   (vec_pull_no),
    .mask_o        (mask_o),
    .sp_o          (sp_o),
    .target_o      (target_o),
    .done_o        (done_o),
    .flags_o       (flags_q),
    .is_brk_o      (is_brk)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic          grant_o,
  input logic          busy_o,
  input logic [AW-1:0] addr_o,
  input logic          we_o,
  input logic          vec_pull_no,
  input logic          mask_o,
  input logic          done_o
);
  AST_GRANT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> busy_o); // R2
  AST_NO_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !grant_o); // R2
  AST_PUSH_STACK_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> addr_o[AW-1:DW] == 8'h01); // R6
  AST_PULL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_pull_no |-> (!we_o && busy_o)); // R10
  AST_MASK_IN_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_pull_no |-> mask_o); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_i) |=> ($stable(addr_o) && $stable(we_o))); // R12
  AST_DONE_AFTER_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!vec_pull_no)); // R14
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .grant_o(grant_o),
  .busy_o(busy_o), .addr_o(addr_o), .we_o(we_o), .vec_pull_no(vec_pull_no),
  .mask_o(mask_o), .done_o(done_o)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, step_i, boundary_i, brk_i, irq_ni, nmi_ni;
  logic [15:0] pc_i;
  logic [7:0]  sp_i, flags_i;
  logic        restore_i, restore_mask_i;
  logic [7:0]  vec_data_i;
  logic        grant_o, busy_o, we_o, vec_pull_no, mask_o, done_o;
  logic [15:0] addr_o, target_o;
  logic [7:0]  wdata_o, sp_o;

  irq_entry_seq u0 (.*);

  assign vec_data_i = vec_pull_no ? 8'h00 : (addr_o[7:0] ^ 8'hA5);

  typedef struct {
    int          kind; // 0 push, 1 vector read, 2 done
    logic [15:0] addr;
    logic [15:0] data;
    string       req;
  } item_t;
  item_t q[$];

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // src: 0 nmi, 1 irq, 2 brk
  task automatic exp_entry(int src, logic [15:0] pc, logic [7:0] sp,
                           logic [7:0] fl, bit mask_before);
    logic [15:0] ret, base;
    logic [7:0]  st;
    ret  = (src == 2) ? pc + 16'd2 : pc;
    st   = (fl & 8'hCB) | 8'h20 | ((src == 2) ? 8'h10 : 8'h00) | (mask_before ? 8'h04 : 8'h00);
    base = (src == 0) ? 16'hFFFA : 16'hFFFE;
    q.push_back('{0, {8'h01, sp},          {8'h00, ret[15:8]}, "R6"});
    q.push_back('{0, {8'h01, sp - 8'd1},   {8'h00, ret[7:0]},  (src == 2) ? "R8" : "R6"});
    q.push_back('{0, {8'h01, sp - 8'd2},   {8'h00, st},        "R7"});
    q.push_back('{1, base,                 16'h0,              (src == 0) ? "R2" : "R5"});
    q.push_back('{1, base | 16'h1,         16'h0,              "R10"});
    q.push_back('{2, 16'h0, {base[7:0] ^ 8'hA5 ^ 8'h01, base[7:0] ^ 8'hA5}, "R14"});
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni && busy_o && step_i && (we_o || !vec_pull_no)) begin
        if (q.size() == 0) chk(0, "R10", "unexpected bus cycle addr", {16'h0, addr_o}, 32'h0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(it.kind == (we_o ? 0 : 1), it.req, "bus cycle kind", {31'h0, we_o}, it.kind);
          chk(addr_o == it.addr, it.req, "bus address", {16'h0, addr_o}, {16'h0, it.addr});
          if (we_o)
            chk(wdata_o == it.data[7:0], it.req, "push data", {24'h0, wdata_o}, {24'h0, it.data[7:0]});
        end
      end
      if (rst_ni && done_o) begin
        if (q.size() == 0) chk(0, "R14", "unexpected done", 32'h1, 32'h0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(it.kind == 2, "R14", "done position", it.kind, 2);
          chk(target_o == it.data, "R14", "target", {16'h0, target_o}, {16'h0, it.data});
        end
      end
    end
  end

  task automatic boundary(logic [15:0] pc, logic [7:0] sp, logic [7:0] fl, bit brk, output bit g);
    @(negedge clk_i);
    pc_i = pc; sp_i = sp; flags_i = fl; brk_i = brk; boundary_i = 1'b1;
    #1 g = grant_o;
    @(negedge clk_i);
    boundary_i = 1'b0; brk_i = 1'b0;
  endtask

  task automatic wait_idle(string req);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); #2;
      if (!busy_o && q.size() == 0) break;
    end
    chk(q.size() == 0, req, "expected items left", q.size(), 0);
  endtask

  task automatic restore(bit m);
    @(negedge clk_i);
    restore_i = 1'b1; restore_mask_i = m;
    @(negedge clk_i);
    restore_i = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit g;
    logic [15:0] a;
    rst_ni = 0; step_i = 1; boundary_i = 0; brk_i = 0; irq_ni = 1; nmi_ni = 1;
    pc_i = 0; sp_i = 8'hFF; flags_i = 0; restore_i = 0; restore_mask_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1
    chk(mask_o == 1, "R1", "mask after reset", mask_o, 1);
    chk(we_o == 0 && vec_pull_no == 1, "R1", "strobes after reset", {we_o, vec_pull_no}, 2'b01);
    chk(busy_o == 0 && done_o == 0, "R1", "idle after reset", {busy_o, done_o}, 0);

    // R5 masked request ignored
    irq_ni = 0;
    boundary(16'h1000, 8'hFF, 8'h00, 0, g);
    chk(g == 0, "R5", "grant while masked", g, 0);
    #1 chk(busy_o == 0, "R5", "busy while masked", busy_o, 0);

    // R13 restore clears mask
    restore(0);
    chk(mask_o == 0, "R13", "mask after restore", mask_o, 0);

    // R5 unmasked request taken, R7 status, R9 mask set
    exp_entry(1, 16'h1234, 8'hFF, 8'hC3, 0);
    boundary(16'h1234, 8'hFF, 8'hC3, 0, g);
    chk(g == 1, "R5", "grant unmasked", g, 1);
    wait_idle("R5");
    chk(mask_o == 1, "R9", "mask after entry", mask_o, 1);
    chk(sp_o == 8'hFC, "R6", "final stack offset", sp_o, 8'hFC);
    irq_ni = 1;

    // R8 software break
    exp_entry(2, 16'h2000, 8'hF0, 8'h41, 1);
    boundary(16'h2000, 8'hF0, 8'h41, 1, g);
    chk(g == 1, "R8", "break grant", g, 1);
    wait_idle("R8");

    // R2 nmi edge, R3 no retrigger while low
    @(negedge clk_i); nmi_ni = 0;
    exp_entry(0, 16'h3000, 8'hE0, 8'h00, 1);
    boundary(16'h3000, 8'hE0, 8'h00, 0, g);
    chk(g == 1, "R2", "nmi grant", g, 1);
    wait_idle("R2");
    boundary(16'h3010, 8'hDD, 8'h00, 0, g);
    chk(g == 0, "R3", "held-low nmi regrant", g, 0);
    @(negedge clk_i); nmi_ni = 1;
    @(negedge clk_i); nmi_ni = 0;
    exp_entry(0, 16'h3020, 8'hDD, 8'h80, 1);
    boundary(16'h3020, 8'hDD, 8'h80, 0, g);
    chk(g == 1, "R3", "nmi after new fall", g, 1);
    wait_idle("R3");
    @(negedge clk_i); nmi_ni = 1;

    // R4 nmi fall during a running sequence
    restore(0);
    irq_ni = 0;
    exp_entry(1, 16'h4000, 8'hD0, 8'h80, 0);
    boundary(16'h4000, 8'hD0, 8'h80, 0, g);
    @(negedge clk_i); nmi_ni = 0;
    wait_idle("R4");
    irq_ni = 1;
    exp_entry(0, 16'h4100, 8'hCD, 8'h02, 1);
    boundary(16'h4100, 8'hCD, 8'h02, 0, g);
    chk(g == 1, "R4", "nmi armed during entry", g, 1);
    wait_idle("R4");
    @(negedge clk_i); nmi_ni = 1;

    // R11 priority
    restore(0);
    @(negedge clk_i); irq_ni = 0; nmi_ni = 0;
    exp_entry(0, 16'h5000, 8'hB0, 8'hFF, 0);
    boundary(16'h5000, 8'hB0, 8'hFF, 0, g);
    chk(g == 1, "R11", "priority grant", g, 1);
    wait_idle("R11");
    chk(mask_o == 1, "R9", "mask after nmi entry", mask_o, 1);
    @(negedge clk_i); irq_ni = 1; nmi_ni = 1;

    // R12 stall
    exp_entry(2, 16'h6000, 8'hA0, 8'h08, 1);
    boundary(16'h6000, 8'hA0, 8'h08, 1, g);
    step_i = 0;
    #1 a = addr_o;
    chk(a == 16'h01A0, "R12", "first push address", {16'h0, a}, 32'h01A0);
    @(negedge clk_i); #1;
    chk(addr_o == a && we_o == 1, "R12", "held during stall", {15'h0, we_o, addr_o}, {15'h0, 1'b1, a});
    @(negedge clk_i); step_i = 1;
    wait_idle("R12");

    // R6 stack wrap
    exp_entry(2, 16'h7000, 8'h01, 8'h00, 1);
    boundary(16'h7000, 8'h01, 8'h00, 1, g);
    wait_idle("R6");
    chk(sp_o == 8'hFE, "R6", "wrapped stack offset", sp_o, 8'hFE);

    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule